// File: doc/BRIEF.md
# Per-Port Cell Error Statistics Counters

This block keeps three saturating 16-bit error counters for each physical port of a cell-based receive interface. It counts dropped cells for three causes. The first is a receive-interface protocol fault: a parity error, a header-check error, or a start-of-cell strobe that does not arrive where the handshake requires it. The second is an address lookup failure, which marks a misinserted cell. The third is a CRC-10 failure on a channel flagged as ABR-type. Upstream logic parses the cell, computes the header check and CRC, and performs the lookup. It delivers the outcome as a per-cell report strobe tagged with a port number.

The block checks start-of-cell timing itself. It watches the receive enable and cell-available signals. When enable rises while a cell is available on the selected port, start-of-cell must appear in the very next cycle. If it does not, that port's protocol counter is charged.

The host reaches the counters through a byte-addressed read/clear port. Each port owns an 8-byte record at a base address plus eight times the port number. Reads return data one cycle later. A write to a counter address clears that counter.

Top module: `phy_err_stat`

## Requirements
- R1: The counter for port p and field f is at byte address stat_base + 8*p + 2*f. Field 0 is the protocol counter, 1 the lookup counter, 2 the CRC-10 counter. A read strobe places the value on host_rdata at the next clock edge.
- R2: Offset 6 of each record reads zero. Any address outside [stat_base, stat_base + 8*NUM_PORTS) also reads zero. Writes to such addresses change no counter.
- R3: A report with rpt_parity_err or rpt_hec_err set increments the protocol counter of rpt_port.
- R4: When rx_enb rises (high now, low in the previous cycle) with rx_avail high, rx_soc must be high in the following cycle. Otherwise the protocol counter of the rx_port sampled at the rise increments by one, whether start-of-cell comes late or not at all. No check is armed when rx_avail is low.
- R5: A port's protocol counter rises by at most one per cycle, even when parity, header-check and a timing fault hit it in the same cycle.
- R6: A report with rpt_lookup_fail set increments the lookup counter of rpt_port.
- R7: A report with rpt_crc10_err set increments the CRC-10 counter only when rpt_abr is also high.
- R8: Counters stop at 0xFFFF and do not wrap.
- R9: A host write to a counter address clears that counter. If an increment reaches the same counter in that cycle, the clear wins.
- R10: After reset every counter and host_rdata are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stat_base | input | ADDR_W | Byte base address of the counter records |
| rx_enb | input | 1 | Receive enable, active high |
| rx_avail | input | 1 | Cell available from the selected port |
| rx_soc | input | 1 | Start-of-cell strobe |
| rx_port | input | PORT_W | Port selected for the handshake |
| rpt_valid | input | 1 | Per-cell error report strobe |
| rpt_port | input | PORT_W | Port of the reported cell |
| rpt_parity_err | input | 1 | Parity error on the cell |
| rpt_hec_err | input | 1 | Header-check error on the cell |
| rpt_lookup_fail | input | 1 | Address lookup failed |
| rpt_crc10_err | input | 1 | CRC-10 failed |
| rpt_abr | input | 1 | Cell belongs to an ABR-type channel |
| host_addr | input | ADDR_W | Host byte address |
| host_rd | input | 1 | Host read strobe |
| host_wr | input | 1 | Host write (clear) strobe |
| host_rdata | output | CNT_W | Read data, valid the cycle after host_rd |

## Verification
The bench targets the timing check from several angles: a punctual start-of-cell, a late one, a missing one, and a rise of enable with no cell available. A design that watched the wrong cycle would either charge punctual cells or let late ones through. It also lines up a timing fault with a parity and header-check report on the same port. A design that summed the causes would count two or three instead of one. A clear is issued in the same cycle as an increment, and a design with the wrong priority would read back one. A counter is driven past 0xFFFF, and a wrapping design would show a small value. Reads go to the reserved slot, above the last record and below the base, and stray writes go to the reserved slot. Each of these would expose a decoder that aliases onto a real counter.

// File: rtl/phy_err_stat_pkg.sv
package phy_err_stat_pkg;

    localparam int NUM_FIELDS = 3;
    localparam int DEC_PORT_W = 8;

    typedef enum logic [1:0] {
        FLD_PROTO  = 2'd0,
        FLD_LOOKUP = 2'd1,
        FLD_CRC    = 2'd2,
        FLD_RSVD   = 2'd3
    } stat_field_e;

    typedef struct packed {
        logic                  hit;
        logic [DEC_PORT_W-1:0] port;
        stat_field_e           field;
    } host_dec_t;

    function automatic logic [15:0] field_offset(input stat_field_e f);
        return {13'd0, f, 1'b0};
    endfunction

endpackage

// File: rtl/stat_addr_decode.sv
module stat_addr_decode
    import phy_err_stat_pkg::*;
#(
    parameter int ADDR_W    = 12,
    parameter int NUM_PORTS = 4
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [ADDR_W-1:0] addr,
    output host_dec_t         dec
);
    logic [ADDR_W-1:0] offset;
    logic [ADDR_W-1:0] rec_idx;

    always_comb begin
        offset    = addr - base;
        rec_idx   = offset >> 3;
        dec.hit   = rec_idx < ADDR_W'(NUM_PORTS);
        dec.port  = DEC_PORT_W'(rec_idx);
        dec.field = stat_field_e'(offset[2:1]);
    end
endmodule

// File: rtl/soc_timing_check.sv
module soc_timing_check #(
    parameter int PORT_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_enb,
    input  logic              rx_avail,
    input  logic              rx_soc,
    input  logic [PORT_W-1:0] rx_port,
    output logic              miss,
    output logic [PORT_W-1:0] miss_port
);
    logic              enb_q;
    logic              armed_q;
    logic [PORT_W-1:0] port_q;
    logic              arm;

    assign arm = rx_enb & ~enb_q & rx_avail;

    always_ff @(posedge clk) begin
        if (rst) begin
            enb_q   <= 1'b0;
            armed_q <= 1'b0;
            port_q  <= '0;
        end else begin
            enb_q   <= rx_enb;
            armed_q <= arm;
            if (arm) port_q <= rx_port;
        end
    end

    assign miss      = armed_q & ~rx_soc;
    assign miss_port = port_q;

    // R4
    soc_window_chk: assert property (@(posedge clk) disable iff (rst)
        (rx_enb && !enb_q && rx_avail) |=> (miss != rx_soc));

    // R4
    no_arm_chk: assert property (@(posedge clk) disable iff (rst)
        !rx_avail |=> !miss);
endmodule

// File: rtl/sat_err_counter.sv
module sat_err_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             inc,
    output logic [CNT_W-1:0] cnt
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    always_ff @(posedge clk) begin
        if (rst || clr)
            cnt <= '0;
        else if (inc && cnt != CNT_MAX)
            cnt <= cnt + 1'b1;
    end

    // R9
    clr_wins_chk: assert property (@(posedge clk) disable iff (rst)
        clr |=> cnt == '0);

    // R8
    sat_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!clr && cnt == CNT_MAX) |=> cnt == CNT_MAX);

    // R5
    one_step_chk: assert property (@(posedge clk) disable iff (rst)
        !clr |=> (cnt == $past(cnt) || cnt == $past(cnt) + 1'b1));
endmodule

// File: rtl/phy_err_stat.sv
module phy_err_stat
    import phy_err_stat_pkg::*;
#(
    parameter int NUM_PORTS = 4,
    parameter int CNT_W     = 16,
    parameter int ADDR_W    = 12,
    parameter int PORT_W    = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] stat_base,
    input  logic              rx_enb,
    input  logic              rx_avail,
    input  logic              rx_soc,
    input  logic [PORT_W-1:0] rx_port,
    input  logic              rpt_valid,
    input  logic [PORT_W-1:0] rpt_port,
    input  logic              rpt_parity_err,
    input  logic              rpt_hec_err,
    input  logic              rpt_lookup_fail,
    input  logic              rpt_crc10_err,
    input  logic              rpt_abr,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic              host_rd,
    input  logic              host_wr,
    output logic [CNT_W-1:0]  host_rdata
);
    host_dec_t         dec;
    logic              miss;
    logic [PORT_W-1:0] miss_port;
    logic [CNT_W-1:0]  cnt [NUM_PORTS][NUM_FIELDS];

    stat_addr_decode #(.ADDR_W(ADDR_W), .NUM_PORTS(NUM_PORTS)) u_dec (
        .base (stat_base),
        .addr (host_addr),
        .dec  (dec)
    );

    soc_timing_check #(.PORT_W(PORT_W)) u_soc (
        .clk       (clk),
        .rst       (rst),
        .rx_enb    (rx_enb),
        .rx_avail  (rx_avail),
        .rx_soc    (rx_soc),
        .rx_port   (rx_port),
        .miss      (miss),
        .miss_port (miss_port)
    );

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        logic                  rpt_hit;
        logic [NUM_FIELDS-1:0] inc;

        assign rpt_hit = rpt_valid && (rpt_port == PORT_W'(p));
        assign inc[FLD_PROTO]  = (rpt_hit && (rpt_parity_err || rpt_hec_err))
                              || (miss && miss_port == PORT_W'(p));
        assign inc[FLD_LOOKUP] = rpt_hit && rpt_lookup_fail;
        assign inc[FLD_CRC]    = rpt_hit && rpt_crc10_err && rpt_abr;

        for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_fld
            logic clr;
            assign clr = host_wr && dec.hit
                      && dec.port == DEC_PORT_W'(p)
                      && dec.field == stat_field_e'(f);

            sat_err_counter #(.CNT_W(CNT_W)) u_cnt (
                .clk (clk),
                .rst (rst),
                .clr (clr),
                .inc (inc[f]),
                .cnt (cnt[p][f])
            );
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            host_rdata <= '0;
        else if (host_rd) begin
            if (dec.hit && dec.field != FLD_RSVD)
                host_rdata <= cnt[dec.port[PORT_W-1:0]][dec.field];
            else
                host_rdata <= '0;
        end
    end

    // R2
    rsvd_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (host_rd && dec.field == FLD_RSVD) |=> host_rdata == '0);

    // R2
    out_range_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (host_rd && !dec.hit) |=> host_rdata == '0);
endmodule

// File: tb/phy_err_stat_bench.sv
module phy_err_stat_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NP = 4;
    localparam int AW = 12;
    localparam int PW = 2;

    typedef struct {
        logic [15:0] exp;
        string       tag;
    } exp_item_t;

    logic clk = 0, rst = 1;
    logic [AW-1:0] stat_base = 12'h100;
    logic rx_enb = 0, rx_avail = 0, rx_soc = 0;
    logic [PW-1:0] rx_port = 0, rpt_port = 0;
    logic rpt_valid = 0, rpt_parity_err = 0, rpt_hec_err = 0;
    logic rpt_lookup_fail = 0, rpt_crc10_err = 0, rpt_abr = 0;
    logic [AW-1:0] host_addr = 0;
    logic host_rd = 0, host_wr = 0;
    logic [15:0] host_rdata;

    int total = 0, bad = 0;
    bit finished = 0;
    exp_item_t sb[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    phy_err_stat u_phy_err_stat (
        .clk(clk), .rst(rst), .stat_base(stat_base),
        .rx_enb(rx_enb), .rx_avail(rx_avail), .rx_soc(rx_soc), .rx_port(rx_port),
        .rpt_valid(rpt_valid), .rpt_port(rpt_port),
        .rpt_parity_err(rpt_parity_err), .rpt_hec_err(rpt_hec_err),
        .rpt_lookup_fail(rpt_lookup_fail), .rpt_crc10_err(rpt_crc10_err),
        .rpt_abr(rpt_abr), .host_addr(host_addr), .host_rd(host_rd),
        .host_wr(host_wr), .host_rdata(host_rdata)
    );

    function automatic logic [AW-1:0] ca(int p, int f);
        return stat_base + AW'(8 * p + 2 * f);
    endfunction

    // monitor: pops one expected item per read
    always @(posedge clk) begin
        if (host_rd && !rst) begin
            @(negedge clk);
            if (sb.size() > 0) begin
                exp_item_t it;
                it = sb.pop_front();
                total++;
                if (host_rdata !== it.exp) begin
                    bad++;
                    $display("FAIL %s: actual=%h expected=%h", it.tag, host_rdata, it.exp);
                end
            end
        end
    end

    task automatic rd(input logic [AW-1:0] a, input logic [15:0] e, input string tag);
        exp_item_t it;
        @(negedge clk);
        it.exp = e; it.tag = tag;
        sb.push_back(it);
        host_addr = a; host_rd = 1;
        @(negedge clk);
        host_rd = 0;
        @(negedge clk);
    endtask

    task automatic wr(input logic [AW-1:0] a);
        @(negedge clk);
        host_addr = a; host_wr = 1;
        @(negedge clk);
        host_wr = 0;
    endtask

    task automatic rpt(input int p, input bit par, input bit hec,
                       input bit lk, input bit crc, input bit abr);
        @(negedge clk);
        rpt_port = PW'(p); rpt_valid = 1;
        rpt_parity_err = par; rpt_hec_err = hec; rpt_lookup_fail = lk;
        rpt_crc10_err = crc; rpt_abr = abr;
        @(negedge clk);
        rpt_valid = 0; rpt_parity_err = 0; rpt_hec_err = 0;
        rpt_lookup_fail = 0; rpt_crc10_err = 0; rpt_abr = 0;
    endtask

    // soc_at: 1 = punctual, 2 = late, 0 = never
    task automatic hs(input int p, input bit avail, input int soc_at);
        @(negedge clk);
        rx_port = PW'(p); rx_enb = 1; rx_avail = avail;
        @(negedge clk);
        rx_soc = (soc_at == 1);
        @(negedge clk);
        rx_soc = (soc_at == 2);
        @(negedge clk);
        rx_soc = 0; rx_enb = 0; rx_avail = 0;
        @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        // R10 reset state
        for (int p = 0; p < NP; p++)
            for (int f = 0; f < 3; f++) rd(ca(p, f), 16'h0, "R10 reset zero");

        // R3 parity and header-check reports
        rpt(1, 1, 0, 0, 0, 0);
        rd(ca(1, 0), 16'd1, "R3 parity");
        rpt(1, 0, 1, 0, 0, 0);
        rd(ca(1, 0), 16'd2, "R3 hec");
        // R5 both causes in one report
        rpt(1, 1, 1, 0, 0, 0);
        rd(ca(1, 0), 16'd3, "R5 parity+hec once");
        // R6 lookup fail
        rpt(2, 0, 0, 1, 0, 0);
        rpt(2, 0, 0, 1, 0, 0);
        rd(ca(2, 1), 16'd2, "R6 lookup");
        rd(ca(2, 0), 16'd0, "R6 no protocol charge");
        // R7 CRC only with ABR
        rpt(3, 0, 0, 0, 1, 0);
        rd(ca(3, 2), 16'd0, "R7 crc non-abr ignored");
        rpt(3, 0, 0, 0, 1, 1);
        rd(ca(3, 2), 16'd1, "R7 crc abr");

        // R4 start-of-cell timing
        hs(2, 1, 1);
        rd(ca(2, 0), 16'd0, "R4 punctual soc");
        hs(2, 1, 2);
        rd(ca(2, 0), 16'd1, "R4 late soc");
        hs(2, 1, 0);
        rd(ca(2, 0), 16'd2, "R4 missing soc");
        hs(2, 0, 0);
        rd(ca(2, 0), 16'd2, "R4 no avail no check");

        // R5 timing miss + parity + hec same cycle, same port
        @(negedge clk);
        rx_port = 0; rx_enb = 1; rx_avail = 1;
        @(negedge clk);
        rx_soc = 0; rpt_valid = 1; rpt_port = 0; rpt_parity_err = 1; rpt_hec_err = 1;
        @(negedge clk);
        rpt_valid = 0; rpt_parity_err = 0; rpt_hec_err = 0;
        rx_enb = 0; rx_avail = 0;
        rd(ca(0, 0), 16'd1, "R5 coincident causes once");

        // R2 reserved and out of range
        rd(ca(1, 3), 16'd0, "R2 reserved reads zero");
        rd(stat_base + AW'(8 * NP), 16'd0, "R2 above range");
        rd(stat_base - AW'(2), 16'd0, "R2 below base");
        wr(ca(1, 3));
        rd(ca(1, 0), 16'd3, "R2 reserved write no effect");

        // R9 clear, and clear beats increment
        wr(ca(3, 2));
        rd(ca(3, 2), 16'd0, "R9 clear");
        @(negedge clk);
        host_addr = ca(1, 0); host_wr = 1;
        rpt_valid = 1; rpt_port = 1; rpt_parity_err = 1;
        @(negedge clk);
        host_wr = 0; rpt_valid = 0; rpt_parity_err = 0;
        rd(ca(1, 0), 16'd0, "R9 clear wins");

        // R1 moved base
        stat_base = 12'h200;
        rd(ca(2, 1), 16'd2, "R1 relocated base");
        rd(12'h100 + 12'd18, 16'd0, "R1 old base gone");

        // R8 saturation
        @(negedge clk);
        rpt_valid = 1; rpt_port = 0; rpt_lookup_fail = 1;
        repeat (65540) @(negedge clk);
        rpt_valid = 0; rpt_lookup_fail = 0;
        rd(ca(0, 1), 16'hFFFF, "R8 saturate");
        rd(ca(0, 0), 16'd1, "R8 neighbour untouched");

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule